// File: doc/BRIEF.md
# Timer Event Status and Interrupt Mask Unit

This block sits beside one timer channel and turns its short event pulses into state that software can read. Each of eight event inputs sets its own sticky flag. A read of the status word returns those flags and clears them in the same access. Beside the flags, the status word carries three live bits. They show the channel's clock-enable state and the present levels of its two I/O lines. These live bits are sampled, not stored.

Software chooses which flags may raise the interrupt. It sets mask bits by writing ones to a write-only enable register and clears them by writing ones to a write-only disable register. A read-only register shows the current mask. A single registered output, `irq_o`, is high while any flag is set and its mask bit is also set. Access is a plain register port. Read data is registered and appears one clock after the read strobe.

Top module: `tsm_status_irq`

## Requirements
- R1: After a synchronous reset, all sticky flags and all mask bits are zero, and `irq_o` and `rd_data_o` are zero.
- R2: A one on `evt_i[n]` in a cycle sets status bit n, and the bit stays set until a status read clears it. The event layout is: 0 overflow, 1 load overrun, 2 A compare, 3 B compare, 4 C compare, 5 A loaded, 6 B loaded, 7 external trigger.
- R3: A read at offset 0x20 returns the flags as they stood before the access, and it clears every flag. A second read with no new events returns zero in bits 7:0.
- R4: An event that arrives in the same cycle as a status read is not cleared. It does not appear in that read, and it shows in the next one.
- R5: A write at offset 0x24 sets each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R6: A write at offset 0x28 clears each mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R7: A read at offset 0x2C returns the mask in bits 7:0 and zeros elsewhere. It does not change the flags.
- R8: In a status read, bit 16 shows `clk_on_i`, bit 17 shows `line_a_i` and bit 18 shows `line_b_i`, sampled in the cycle of the read. The other high bits read as zero.
- R9: `irq_o` is registered. It takes the OR over all n of (flag n AND mask n), using the values that the flag and mask registers take at the same clock edge.
- R10: Writes at offsets 0x20 and 0x2C have no effect. Reads at 0x24, 0x28 or any unmapped offset return zero. `rd_data_o` is zero in the cycle after any clock with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Registered read data, valid one clock after the read strobe |
| evt_i | input | EVT_W | Event pulses, one per flag |
| clk_on_i | input | 1 | Live clock-enabled level |
| line_a_i | input | 1 | Live level of I/O line A |
| line_b_i | input | 1 | Live level of I/O line B |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions check, on every cycle, several properties that depend only on register state. A flag never drops without a clear. An event is always captured, even during a clearing read. Enable and disable writes set and clear exactly the bits written. `irq_o` always agrees with the flag and mask registers. Idle read data is zero. Only the bench scenarios can show what software actually sees through the port. Those scenarios cover the values returned by a clearing read, how an event that collides with a read is deferred to the next read, the placement of the live bits, and the correct interrupt level for every one of the 256 mask values against varied event patterns.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int unsigned OFF_STATUS = 32'h20;
  localparam int unsigned OFF_SET    = 32'h24;
  localparam int unsigned OFF_CLR    = 32'h28;
  localparam int unsigned OFF_MASK   = 32'h2C;
  localparam int unsigned LIVE_BASE  = 16;
  localparam int unsigned LIVE_W     = 3;

  typedef struct packed {
    logic line_b;
    logic line_a;
    logic clk_on;
  } live_t;
endpackage

// File: rtl/tsm_decode.sv
module tsm_decode #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_status_o,
  output logic              rd_mask_o,
  output logic              wr_set_o,
  output logic              wr_clr_o
);
  import tsm_pkg::*;

  always_comb begin
    rd_status_o = rd_en_i && (addr_i == ADDR_W'(OFF_STATUS));
    rd_mask_o   = rd_en_i && (addr_i == ADDR_W'(OFF_MASK));
    wr_set_o    = wr_en_i && (addr_i == ADDR_W'(OFF_SET));
    wr_clr_o    = wr_en_i && (addr_i == ADDR_W'(OFF_CLR));
  end
endmodule

// File: rtl/tsm_sticky_flags.sv
module tsm_sticky_flags #(
  parameter int unsigned EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [EVT_W-1:0] evt_i,
  output logic [EVT_W-1:0] flags_o,
  output logic [EVT_W-1:0] flags_d_o
);
  logic [EVT_W-1:0] flags_q;

  for (genvar i = 0; i < EVT_W; i++) begin : g_flag
    // An event has priority over a clear, so it survives a colliding read.
    assign flags_d_o[i] = (flags_q[i] & ~clr_i) | evt_i[i];
    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_d_o[i];
    end
  end

  assign flags_o = flags_q;

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_evt_kept_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((flags_q & ~$past(evt_i)) == '0));
endmodule

// File: rtl/tsm_mask_reg.sv
module tsm_mask_reg #(
  parameter int unsigned EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [EVT_W-1:0] bits_i,
  output logic [EVT_W-1:0] mask_o,
  output logic [EVT_W-1:0] mask_d_o
);
  logic [EVT_W-1:0] mask_q;

  always_comb begin
    mask_d_o = mask_q;
    if (set_i) mask_d_o = mask_q | bits_i;
    else if (clr_i) mask_d_o = mask_q & ~bits_i;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d_o;
  end

  assign mask_o = mask_q;

  assert_mask_set_R5: assert property (@(posedge clk) disable iff (rst)
    set_i |=> (((mask_q & $past(bits_i)) == $past(bits_i)) &&
               ((mask_q & ~$past(bits_i)) == ($past(mask_q) & ~$past(bits_i)))));

  assert_mask_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> (((mask_q & $past(bits_i)) == '0) &&
               ((mask_q & ~$past(bits_i)) == ($past(mask_q) & ~$past(bits_i)))));

  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/tsm_status_irq.sv
module tsm_status_irq #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              clk_on_i,
  input  logic              line_a_i,
  input  logic              line_b_i,
  output logic              irq_o
);
  import tsm_pkg::*;

  localparam int unsigned LIVE_TOP = LIVE_BASE + LIVE_W;

  initial begin
    if (EVT_W > LIVE_BASE || LIVE_TOP > DATA_W)
      $error("tsm_status_irq: status word layout does not fit DATA_W");
  end

  logic             rd_status, rd_mask, wr_set, wr_clr;
  logic [EVT_W-1:0] flags_q, flags_d, mask_q, mask_d;
  logic [DATA_W-1:0] rd_word, rd_q;
  logic             irq_q;
  live_t            live;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^wr_data_i[DATA_W-1:EVT_W];
  assign live = '{line_b: line_b_i, line_a: line_a_i, clk_on: clk_on_i};

  tsm_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .rd_status_o(rd_status),
    .rd_mask_o  (rd_mask),
    .wr_set_o   (wr_set),
    .wr_clr_o   (wr_clr)
  );

  tsm_sticky_flags #(.EVT_W(EVT_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (rd_status),
    .evt_i    (evt_i),
    .flags_o  (flags_q),
    .flags_d_o(flags_d)
  );

  tsm_mask_reg #(.EVT_W(EVT_W)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .set_i   (wr_set),
    .clr_i   (wr_clr),
    .bits_i  (wr_data_i[EVT_W-1:0]),
    .mask_o  (mask_q),
    .mask_d_o(mask_d)
  );

  always_comb begin
    rd_word = '0;
    if (rd_status) begin
      rd_word[EVT_W-1:0]            = flags_q;
      rd_word[LIVE_BASE +: LIVE_W]  = live;
    end else if (rd_mask) begin
      rd_word[EVT_W-1:0]            = mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      rd_q  <= rd_word;
      irq_q <= |(flags_d & mask_d);
    end
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;

  assert_irq_match_R9: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(flags_q & mask_q));

  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> (rd_data_o == '0));

  assert_status_hi_zero_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_data_o[DATA_W-1:LIVE_TOP] == '0));
endmodule

// File: tb/tb_tsm_status_irq.sv
module tb_tsm_status_irq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int EVT_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [EVT_W-1:0]  evt = '0;
  logic clk_on = 1'b0, line_a = 1'b0, line_b = 1'b0;
  logic irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [DATA_W-1:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsm_status_irq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W)) dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .evt_i(evt), .clk_on_i(clk_on),
    .line_a_i(line_a), .line_b_i(line_b), .irq_o(irq)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [EVT_W-1:0] e);
    @(negedge clk); evt = e;
    @(posedge clk);
    @(negedge clk); evt = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    bus_read(8'h2C, got); check("R1 mask", got, 32'h0);
    bus_read(8'h20, got); check("R1 status", got, 32'h0);

    // R2 each event bit alone, sticky across idle cycles
    for (int n = 0; n < EVT_W; n++) begin
      pulse(8'(1 << n));
      repeat (2) @(negedge clk);
      check("R10 idle rdata", rdata, 32'h0);
      bus_read(8'h20, got); check("R2 single event", got, 32'(1 << n));
      bus_read(8'h20, got); check("R3 cleared after read", got, 32'h0);
    end

    // Sweep all masks against varied event patterns: R5 R6 R7 R9 R3
    for (int m = 0; m < 256; m++) begin
      logic [7:0] e;
      e = 8'((m * 37 + 11) ^ (m >> 3));
      bus_write(8'h28, 32'hFF);
      bus_write(8'h24, 32'(m));
      bus_read(8'h2C, got); check("R5 mask set", got, 32'(m));
      check("R9 irq quiet", {31'b0, irq}, 32'h0);
      pulse(e);
      check("R9 irq level", {31'b0, irq}, {31'b0, |(e & 8'(m))});
      bus_read(8'h2C, got); check("R7 mask read no clear", got, 32'(m));
      bus_read(8'h20, got); check("R3 status value", got, 32'(e));
      check("R9 irq after clear", {31'b0, irq}, 32'h0);
    end

    // R6 partial disable keeps other bits
    bus_write(8'h28, 32'hFF);
    bus_write(8'h24, 32'hF0);
    bus_write(8'h24, 32'h0C);
    bus_read(8'h2C, got); check("R5 accumulate", got, 32'hFC);
    bus_write(8'h28, 32'h84);
    bus_read(8'h2C, got); check("R6 partial clear", got, 32'h78);
    pulse(8'h04);
    check("R9 disabled bit no irq", {31'b0, irq}, 32'h0);
    bus_write(8'h24, 32'h04);
    check("R9 irq on late enable", {31'b0, irq}, 32'h1);
    bus_write(8'h28, 32'h04);
    check("R9 irq drops on disable", {31'b0, irq}, 32'h0);
    bus_read(8'h20, got); check("R2 flag held while masked", got, 32'h04);

    // R4 event colliding with status read
    pulse(8'h02);
    @(negedge clk); rd_en = 1'b1; addr = 8'h20; evt = 8'h08;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; evt = '0; got = rdata;
    check("R4 colliding read", got, 32'h02);
    bus_read(8'h20, got); check("R4 event kept", got, 32'h08);
    bus_read(8'h20, got); check("R4 then cleared", got, 32'h0);

    // R8 live bits, all combinations
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); clk_on = k[0]; line_a = k[1]; line_b = k[2];
      bus_read(8'h20, got); check("R8 live bits", got, 32'(k) << 16);
      bus_read(8'h2C, got); check("R8 live absent in mask read", got & 32'hFFFF_FF00, 32'h0);
    end
    @(negedge clk); clk_on = 0; line_a = 0; line_b = 0;

    // R10 read-only writes ignored, write-only reads zero
    bus_write(8'h28, 32'hFF);
    bus_write(8'h2C, 32'hFF);
    bus_read(8'h2C, got); check("R10 mask write ignored", got, 32'h0);
    pulse(8'h10);
    bus_write(8'h20, 32'hFF);
    bus_read(8'h24, got); check("R10 set reg reads zero", got, 32'h0);
    bus_read(8'h28, got); check("R10 clr reg reads zero", got, 32'h0);
    bus_read(8'h30, got); check("R10 unmapped reads zero", got, 32'h0);
    bus_read(8'h20, got); check("R10 status write ignored", got, 32'h10);
    check("R1 irq stays low unmasked", {31'b0, irq}, 32'h0);

    // R1 reset mid-run clears mask and flags
    bus_write(8'h24, 32'hFF);
    pulse(8'hA5);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    bus_read(8'h2C, got); check("R1 mask after reset", got, 32'h0);
    bus_read(8'h20, got); check("R1 flags after reset", got, 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule